// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called side A and side B, and can pass data either way between them. Each direction has its own storage register with its own capture clock. The A-to-B register samples side A, and the B-to-A register samples side B. Sampling never depends on which side is driving, so a register can pick up bus traffic even while the block is isolated from both buses.

A single active-low enable and a direction input choose which side the block drives, if any. Each direction also has a select input. The select decides whether the driven side receives live data from the opposite bus, or the value held in that direction's register. Data is never inverted on any path.

Each bus is split into input, output and per-bit output-enable vectors, so no internal tri-state nets are needed. A parameter can force an undriven output to zero so that it does not toggle.

Top module: `xr_bus_bridge`

## Requirements
- R1: An active-low asynchronous reset clears both storage registers to zero. Reading either register through the stored path returns 0 while reset is held and after it is released.
- R2: The A-to-B register loads `a_in` on each rising edge of `clk_ab`, and the B-to-A register loads `b_in` on each rising edge of `clk_ba`. An edge on one clock leaves the other register unchanged.
- R3: Both registers load on their clock edges whatever the values of `en_n`, `dir_to_b`, `pick_ab` and `pick_ba`. This includes while `en_n` is 1.
- R4: While `en_n` is 1, both `a_oe` and `b_oe` are all zeros, so neither side is driven.
- R5: While `en_n` is 0 and `dir_to_b` is 0, `a_oe` is all ones and `b_oe` is all zeros. In that state `a_out` equals `b_in` when `pick_ba` is 0, and equals the B-to-A register when `pick_ba` is 1. In that state `pick_ab` has no effect on the outputs.
- R6: While `en_n` is 0 and `dir_to_b` is 1, `b_oe` is all ones and `a_oe` is all zeros. In that state `b_out` equals `a_in` when `pick_ab` is 0, and equals the A-to-B register when `pick_ab` is 1. In that state `pick_ba` has no effect on the outputs.
- R7: `a_oe` and `b_oe` are never non-zero together. Each of them is always either all zeros or all ones.
- R8: When `clk_ab` and `clk_ba` rise at the same instant, both registers load their own bus in that edge.
- R9: With `PARK_ZERO` = 1 (the default), an output whose enable vector is zero reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock of the A-to-B register, rising edge |
| clk_ba | input | 1 | Capture clock of the B-to-A register, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| en_n | input | 1 | Active-low output enable; 1 isolates both sides |
| dir_to_b | input | 1 | 1 drives side B, 0 drives side A (when enabled) |
| pick_ab | input | 1 | 0 sends live A data to B, 1 sends the A-to-B register |
| pick_ba | input | 1 | 0 sends live B data to A, 1 sends the B-to-A register |
| a_in | input | WIDTH | Value seen on side A |
| a_out | output | WIDTH | Value the block drives onto side A |
| a_oe | output | WIDTH | Per-bit drive enable for side A |
| b_in | input | WIDTH | Value seen on side B |
| b_out | output | WIDTH | Value the block drives onto side B |
| b_oe | output | WIDTH | Per-bit drive enable for side B |

## Verification
The register assertions assume that every capture clock edge comes from a glitch-free clock. They also assume that the bus inputs are stable at that edge. The bench meets this by changing data and controls only on the falling edge of its base clock, and by gating each capture clock with a flag that also changes only at that falling edge. The output assertions are sampled on the capture clocks. They assume the control inputs are settled at those edges, and the bench holds the controls steady for a full cycle around every pulse.

// File: rtl/xr_pkg.sv
package xr_pkg;

   // Which side of the bridge is driven this cycle.
   typedef enum logic [1:0] {
      XR_ISOLATE = 2'd0,
      XR_TO_A    = 2'd1,
      XR_TO_B    = 2'd2
   } xr_drive_e;

   function automatic xr_drive_e xr_decode(input logic en_n, input logic dir_to_b);
      xr_drive_e r;
      if (en_n)          r = XR_ISOLATE;
      else if (dir_to_b) r = XR_TO_B;
      else               r = XR_TO_A;
      return r;
   endfunction

endpackage

// File: rtl/xr_store_reg.sv
module xr_store_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xr_store_reg: WIDTH must be at least 1");
      end
   endgenerate

   // Capture is unconditional: no enable, every rising edge loads.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end

   // R2 / R3: after any edge the register holds what the bus showed at it.
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/xr_path_sel.sv
module xr_path_sel #(
   parameter int WIDTH = 8
) (
   input  logic             pick_stored,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] y
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xr_path_sel: WIDTH must be at least 1");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign y[i] = pick_stored ? stored[i] : live[i];
      end
   endgenerate

endmodule

// File: rtl/xr_port_ctl.sv
module xr_port_ctl
   import xr_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic             en_n,
   input  logic             dir_to_b,
   input  logic [WIDTH-1:0] val_to_a,
   input  logic [WIDTH-1:0] val_to_b,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);

   xr_drive_e mode;
   logic      drv_a;
   logic      drv_b;

   assign mode = xr_decode(en_n, dir_to_b);

   always_comb begin
      drv_a = 1'b0;
      drv_b = 1'b0;
      unique case (mode)
         XR_TO_A:    drv_a = 1'b1;
         XR_TO_B:    drv_b = 1'b1;
         XR_ISOLATE: ;
         default:    ;
      endcase
   end

   assign a_oe = {WIDTH{drv_a}};
   assign b_oe = {WIDTH{drv_b}};

   generate
      if (PARK_ZERO) begin : g_park
         assign a_out = drv_a ? val_to_a : '0;
         assign b_out = drv_b ? val_to_b : '0;
      end else begin : g_pass
         assign a_out = val_to_a;
         assign b_out = val_to_b;
      end
   endgenerate

endmodule

// File: rtl/xr_bus_bridge.sv
module xr_bus_bridge #(
   parameter int WIDTH     = 8,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             dir_to_b,
   input  logic             pick_ab,
   input  logic             pick_ba,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xr_bus_bridge: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] held_ab;
   logic [WIDTH-1:0] held_ba;
   logic [WIDTH-1:0] toward_b;
   logic [WIDTH-1:0] toward_a;

   xr_store_reg #(.WIDTH(WIDTH)) u_reg_ab (
      .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(held_ab)
   );

   xr_store_reg #(.WIDTH(WIDTH)) u_reg_ba (
      .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(held_ba)
   );

   xr_path_sel #(.WIDTH(WIDTH)) u_sel_ab (
      .pick_stored(pick_ab), .live(a_in), .stored(held_ab), .y(toward_b)
   );

   xr_path_sel #(.WIDTH(WIDTH)) u_sel_ba (
      .pick_stored(pick_ba), .live(b_in), .stored(held_ba), .y(toward_a)
   );

   xr_port_ctl #(.WIDTH(WIDTH), .PARK_ZERO(PARK_ZERO)) u_ctl (
      .en_n(en_n), .dir_to_b(dir_to_b),
      .val_to_a(toward_a), .val_to_b(toward_b),
      .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   // R7: at most one side driven, enables are whole-bus
   a_r7_single_driver: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !((|a_oe) && (|b_oe)) && ((a_oe == '0) || (&a_oe)));

   // R4: isolation leaves both sides undriven
   a_r4_isolated: assert property (@(posedge clk_ba) disable iff (!rst_n)
      en_n |-> ((a_oe == '0) && (b_oe == '0)));

   // R6: live A data reaches side B unchanged
   a_r6_live_to_b: assert property (@(posedge clk_ab) disable iff (!rst_n)
      (!en_n && dir_to_b && !pick_ab) |-> ((b_out == a_in) && (&b_oe)));

   // R5: stored B data reaches side A
   a_r5_stored_to_a: assert property (@(posedge clk_ba) disable iff (!rst_n)
      (!en_n && !dir_to_b && pick_ba) |-> ((a_out == held_ba) && (&a_oe)));

endmodule

// File: tb/sim_xr_bus_bridge.sv
module sim_xr_bus_bridge;

   localparam int W = 8;

   typedef struct packed {
      logic         en_n;
      logic         dir;
      logic         pab;
      logic         pba;
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic         aoe;
      logic         boe;
      logic [W-1:0] ea;
      logic [W-1:0] eb;
   } row_t;

   // Registers preloaded with A-to-B = 3C, B-to-A = A5 before this table.
   localparam row_t ROWS [8] = '{
      '{1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 1'b0, 1'b0, 8'h00, 8'h00},
      '{1'b1, 1'b1, 1'b1, 1'b1, 8'h33, 8'h44, 1'b0, 1'b0, 8'h00, 8'h00},
      '{1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h66, 1'b1, 1'b0, 8'h66, 8'h00},
      '{1'b0, 1'b0, 1'b0, 1'b1, 8'h77, 8'h88, 1'b1, 1'b0, 8'hA5, 8'h00},
      '{1'b0, 1'b1, 1'b0, 1'b0, 8'h99, 8'hAA, 1'b0, 1'b1, 8'h00, 8'h99},
      '{1'b0, 1'b1, 1'b1, 1'b0, 8'hBB, 8'hCC, 1'b0, 1'b1, 8'h00, 8'h3C},
      '{1'b0, 1'b0, 1'b1, 1'b0, 8'hDD, 8'h0F, 1'b1, 1'b0, 8'h0F, 8'h00},
      '{1'b0, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h01, 1'b0, 1'b1, 8'h00, 8'hF0}
   };

   logic clk = 1'b0;
   logic cap_ab = 1'b0;
   logic cap_ba = 1'b0;
   logic clk_ab, clk_ba;
   logic rst_n = 1'b0;
   logic en_n = 1'b1;
   logic dir_to_b = 1'b0;
   logic pick_ab = 1'b0;
   logic pick_ba = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] a_out, a_oe, b_out, b_oe;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   assign clk_ab = clk & cap_ab;
   assign clk_ba = clk & cap_ba;

   xr_bus_bridge #(.WIDTH(W)) u0 (
      .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
      .en_n(en_n), .dir_to_b(dir_to_b), .pick_ab(pick_ab), .pick_ba(pick_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic set_ctl(input logic e, input logic d, input logic pab, input logic pba);
      en_n = e; dir_to_b = d; pick_ab = pab; pick_ba = pba;
   endtask

   // One rising edge on the chosen capture clocks; returns 1 ns after the next falling edge.
   task automatic pulse(input logic do_ab, input logic do_ba);
      @(negedge clk);
      cap_ab = do_ab;
      cap_ba = do_ba;
      @(negedge clk);
      cap_ab = 1'b0;
      cap_ba = 1'b0;
      #1;
   endtask

   task automatic settle;
      @(negedge clk);
      #1;
   endtask

   // Read both registers through the stored paths, restoring nothing.
   task automatic read_regs(input string tag, input logic [W-1:0] exp_ab, input logic [W-1:0] exp_ba);
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      settle();
      chk({tag, " A-to-B reg"}, b_out, exp_ab);
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      settle();
      chk({tag, " B-to-A reg"}, a_out, exp_ba);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      read_regs("R1 during reset", 8'h00, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      read_regs("R1 after reset", 8'h00, 8'h00);

      // R2: independent captures
      set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
      a_in = 8'h3C; b_in = 8'h77;
      pulse(1'b1, 1'b0);
      read_regs("R2 clk_ab only", 8'h3C, 8'h00);
      a_in = 8'h66; b_in = 8'hA5;
      pulse(1'b0, 1'b1);
      read_regs("R2 clk_ba only", 8'h3C, 8'hA5);

      // Table walk: R4 R5 R6 R7 R9
      for (int i = 0; i < 8; i++) begin
         set_ctl(ROWS[i].en_n, ROWS[i].dir, ROWS[i].pab, ROWS[i].pba);
         a_in = ROWS[i].a;
         b_in = ROWS[i].b;
         settle();
         chk($sformatf("R4/R5/R6/R7 row %0d a_oe", i), a_oe, {W{ROWS[i].aoe}});
         chk($sformatf("R4/R5/R6/R7 row %0d b_oe", i), b_oe, {W{ROWS[i].boe}});
         chk($sformatf("R5/R9 row %0d a_out", i), a_out, ROWS[i].ea);
         chk($sformatf("R6/R9 row %0d b_out", i), b_out, ROWS[i].eb);
      end
      read_regs("R2 table left regs", 8'h3C, 8'hA5);

      // R3: capture while isolated, then transfer stored value
      set_ctl(1'b1, 1'b1, 1'b1, 1'b1);
      a_in = 8'h5A; b_in = 8'h96;
      pulse(1'b1, 1'b1);
      chk("R3 isolated a_oe", a_oe, 8'h00);
      read_regs("R3 isolated capture", 8'h5A, 8'h96);

      // R3: capture of B while side A is driven from the stored path
      set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
      b_in = 8'hC3;
      pulse(1'b0, 1'b1);
      chk("R3 stored-to-A after capture", a_out, 8'hC3);

      // R8: simultaneous edges
      set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
      a_in = 8'h12; b_in = 8'h34;
      pulse(1'b1, 1'b1);
      a_in = 8'h00; b_in = 8'h00;
      read_regs("R8 both clocks", 8'h12, 8'h34);

      // R1: reset in the middle of operation
      set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
      settle();
      chk("R1 before mid reset", b_out, 8'h12);
      rst_n = 1'b0;
      #1;
      chk("R1 async clear", b_out, 8'h00);
      settle();
      rst_n = 1'b1;
      read_regs("R1 after mid reset", 8'h00, 8'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog R1..R9 act=timeout exp=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule